// File: doc/BRIEF.md
# Flash Command Staging Slot and Bank Dispatcher

This block sits between the firmware's register writes and a set of flash bank engines. Software fills a set of staging registers: opcode, target bank, option flags, a pause mask, and one high-chip row value per bank. It then writes the issue register. That write takes a snapshot of the staging registers into a single waiting slot and stamps it with a rolling command number. The staging registers keep their contents, so software can prepare the next command while the current one waits.

Each bank owns a status port and a busy flag. When the slot holds a command, the block hands it over if the addressed bank is idle and the block is not paused. On that handover the bank's status port takes the slot contents, the bank becomes busy and the slot empties. A bank stays busy until its engine pulses a done line.

The target code 0x3F hands the command to any idle bank whose high-chip row is not all ones. A global pause is raised while any bank's interrupt flags overlap the pause mask.

Top module: `cmd_stage_dispatch`

## Requirements
- R1: A write to the issue address (4) copies the staged opcode (address 0, bits 7:0), target (address 1, bits 5:0), option (address 2, bits 7:0) and per-bank rows (address 32+k) into the slot and marks it full. Hardware never alters the staged registers, so a second issue with no rewrite repeats the same opcode and target.
- R2: The slot holds one command. It empties on handover or on a write to the abort address (5). An aborted command reaches no bank. An abort while the slot is empty changes nothing.
- R3: A bank takes the slot only while idle. On the clock edge of handover its busy output rises and its status port takes the opcode, option, command number and that bank's row. A bank leaves busy on the edge where its done input is high.
- R4: A bank's status port keeps its value on every cycle without a handover to that bank.
- R5: Target code 0x3F selects among idle banks. When several qualify in the same cycle, the lowest-numbered bank takes the command.
- R6: Under target 0x3F, a bank whose staged high-chip row is all ones is never chosen.
- R7: `stat_flags` bit 0 is 1 exactly while the slot is full. Bit 1 is 1 exactly while paused. Both are 0 after reset.
- R8: The command number is 10 bits wide and starts at 0 after reset. Every issue increments it, including an issue that is later aborted. The value at issue travels into the accepting bank's status port.
- R9: Pause is 1 while, for some bank k, the bitwise AND of the pause mask (address 3) with `bank_intr` field k is non-zero. No handover happens while paused.
- R10: `auto_bank` holds the number of the bank that took the most recent 0x3F command. A directed handover leaves it unchanged. It resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| bank_done | input | NUM_BANKS | Per-bank completion pulse |
| bank_intr | input | NUM_BANKS*INTR_W | Per-bank interrupt flag fields |
| stat_flags | output | 2 | {paused, slot full} |
| auto_bank | output | 6 | Bank that took the last auto-select command |
| next_cmd_id | output | ID_W | Number the next issue will carry |
| bank_busy | output | NUM_BANKS | Per-bank busy flags |
| acc_valid | output | 1 | High for one cycle after each handover |
| acc_bank | output | 6 | Bank of the last handover |
| bsp_op | output | NUM_BANKS*OP_W | Per-bank status port: opcode |
| bsp_opt | output | NUM_BANKS*OPT_W | Per-bank status port: option flags |
| bsp_id | output | NUM_BANKS*ID_W | Per-bank status port: command number |
| bsp_row | output | NUM_BANKS*ROW_W | Per-bank status port: row |

## Verification
A stuck slot-full flag leaves status bit 0 high and blocks later handovers. The fault shows one cycle after the expected handover, while the bank's done state is known.

A wrong pick shows up on the next `acc_valid`, where the scoreboard compares the bank, opcode and command number of every handover in issue order. If the pick ignores the pause or the all-ones exclusion, a handover appears while the scoreboard expects none, or it names an excluded bank. If a status port changes outside a handover, the stored command number differs from the one the bench saw earlier.

// File: rtl/cmd_stage_pkg.sv
package cmd_stage_pkg;
  localparam int BANK_W = 6;
  localparam logic [BANK_W-1:0] AUTO_SEL = 6'h3F;

  localparam int A_OPCODE   = 0;
  localparam int A_TARGET   = 1;
  localparam int A_OPTION   = 2;
  localparam int A_PMASK    = 3;
  localparam int A_ISSUE    = 4;
  localparam int A_ABORT    = 5;
  localparam int A_ROW_BASE = 32;

  // decide whether a slot target selects bank k
  function automatic logic target_hits(input logic [BANK_W-1:0] tgt,
                                       input int k, input logic row_blocked);
    if (tgt == AUTO_SEL) return !row_blocked;
    return tgt == BANK_W'(k);
  endfunction
endpackage

// File: rtl/bank_pick.sv
module bank_pick #(
  parameter int NUM_BANKS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] req,
  output logic [NUM_BANKS-1:0] grant,
  output logic                 any,
  output logic [5:0]           idx
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = 6'(i);
      end
    end
  end
  assign any = |req;

  assert_one_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_in_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
  assert_lowest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((req & (grant - 1'b1)) == '0));
endmodule

// File: rtl/pause_detect.sv
module pause_detect #(
  parameter int NUM_BANKS = 8,
  parameter int INTR_W    = 8
) (
  input  logic [INTR_W-1:0]           mask,
  input  logic [NUM_BANKS*INTR_W-1:0] intr,
  output logic                        paused
);
  logic [NUM_BANKS-1:0] hit;
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_hit
    assign hit[g] = |(mask & intr[g*INTR_W +: INTR_W]);
  end
  assign paused = |hit;
endmodule

// File: rtl/bank_port.sv
module bank_port #(
  parameter int OP_W  = 8,
  parameter int OPT_W = 8,
  parameter int ID_W  = 10,
  parameter int ROW_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             done,
  input  logic [OP_W-1:0]  d_op,
  input  logic [OPT_W-1:0] d_opt,
  input  logic [ID_W-1:0]  d_id,
  input  logic [ROW_W-1:0] d_row,
  output logic             busy,
  output logic [OP_W-1:0]  q_op,
  output logic [OPT_W-1:0] q_opt,
  output logic [ID_W-1:0]  q_id,
  output logic [ROW_W-1:0] q_row
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      q_op  <= '0;
      q_opt <= '0;
      q_id  <= '0;
      q_row <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      q_op  <= d_op;
      q_opt <= d_opt;
      q_id  <= d_id;
      q_row <= d_row;
    end else if (done) begin
      busy <= 1'b0;
    end
  end

  assert_take_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
  assert_busy_now_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
  assert_port_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(q_op) && $stable(q_opt) && $stable(q_id) && $stable(q_row)));
endmodule

// File: rtl/cmd_stage_dispatch.sv
module cmd_stage_dispatch
  import cmd_stage_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int OP_W      = 8,
  parameter int OPT_W     = 8,
  parameter int ROW_W     = 32,
  parameter int ID_W      = 10,
  parameter int INTR_W    = 8,
  parameter int ADDR_W    = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [31:0]                 wr_data,
  input  logic [NUM_BANKS-1:0]        bank_done,
  input  logic [NUM_BANKS*INTR_W-1:0] bank_intr,
  output logic [1:0]                  stat_flags,
  output logic [5:0]                  auto_bank,
  output logic [ID_W-1:0]             next_cmd_id,
  output logic [NUM_BANKS-1:0]        bank_busy,
  output logic                        acc_valid,
  output logic [5:0]                  acc_bank,
  output logic [NUM_BANKS*OP_W-1:0]   bsp_op,
  output logic [NUM_BANKS*OPT_W-1:0]  bsp_opt,
  output logic [NUM_BANKS*ID_W-1:0]   bsp_id,
  output logic [NUM_BANKS*ROW_W-1:0]  bsp_row
);
  // staged image
  logic [OP_W-1:0]   stg_op;
  logic [BANK_W-1:0] stg_tgt;
  logic [OPT_W-1:0]  stg_opt;
  logic [INTR_W-1:0] pause_mask;
  logic [ROW_W-1:0]  stg_row [NUM_BANKS];

  // waiting slot
  logic              slot_full;
  logic [OP_W-1:0]   slot_op;
  logic [BANK_W-1:0] slot_tgt;
  logic [OPT_W-1:0]  slot_opt;
  logic [ID_W-1:0]   slot_id;
  logic [ROW_W-1:0]  slot_row [NUM_BANKS];
  logic [ID_W-1:0]   id_ctr;

  // named internal events
  logic                 issue_wr, abort_wr, issue_take, paused, accept_fire;
  logic [NUM_BANKS-1:0] pick_req, pick_grant;
  logic [5:0]           pick_idx;

  assign issue_wr   = wr_en && (wr_addr == ADDR_W'(A_ISSUE));
  assign abort_wr   = wr_en && (wr_addr == ADDR_W'(A_ABORT));
  assign issue_take = issue_wr && !slot_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_op     <= '0;
      stg_tgt    <= '0;
      stg_opt    <= '0;
      pause_mask <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_OPCODE)) stg_op     <= wr_data[OP_W-1:0];
      if (wr_addr == ADDR_W'(A_TARGET)) stg_tgt    <= wr_data[BANK_W-1:0];
      if (wr_addr == ADDR_W'(A_OPTION)) stg_opt    <= wr_data[OPT_W-1:0];
      if (wr_addr == ADDR_W'(A_PMASK))  pause_mask <= wr_data[INTR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_full <= 1'b0;
      slot_op   <= '0;
      slot_tgt  <= '0;
      slot_opt  <= '0;
      slot_id   <= '0;
      id_ctr    <= '0;
    end else begin
      if (abort_wr || accept_fire) slot_full <= 1'b0;
      else if (issue_take)         slot_full <= 1'b1;
      if (issue_take) begin
        slot_op  <= stg_op;
        slot_tgt <= stg_tgt;
        slot_opt <= stg_opt;
        slot_id  <= id_ctr;
        id_ctr   <= id_ctr + 1'b1;
      end
    end
  end

  pause_detect #(.NUM_BANKS(NUM_BANKS), .INTR_W(INTR_W)) i_pause (
    .mask(pause_mask), .intr(bank_intr), .paused(paused)
  );

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg_row[gi]  <= '0;
        slot_row[gi] <= '0;
      end else begin
        if (wr_en && wr_addr == ADDR_W'(A_ROW_BASE + gi)) stg_row[gi] <= wr_data[ROW_W-1:0];
        if (issue_take) slot_row[gi] <= stg_row[gi];
      end
    end

    assign pick_req[gi] = slot_full && !paused && !abort_wr && !bank_busy[gi] &&
                          target_hits(slot_tgt, gi, slot_row[gi] == '1);

    bank_port #(.OP_W(OP_W), .OPT_W(OPT_W), .ID_W(ID_W), .ROW_W(ROW_W)) i_port (
      .clk(clk), .rst_n(rst_n), .load(pick_grant[gi]), .done(bank_done[gi]),
      .d_op(slot_op), .d_opt(slot_opt), .d_id(slot_id), .d_row(slot_row[gi]),
      .busy(bank_busy[gi]),
      .q_op(bsp_op[gi*OP_W +: OP_W]), .q_opt(bsp_opt[gi*OPT_W +: OPT_W]),
      .q_id(bsp_id[gi*ID_W +: ID_W]), .q_row(bsp_row[gi*ROW_W +: ROW_W])
    );

    assert_auto_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_grant[gi] && slot_tgt == AUTO_SEL) |-> (slot_row[gi] != '1));
  end

  bank_pick #(.NUM_BANKS(NUM_BANKS)) i_pick (
    .clk(clk), .rst_n(rst_n), .req(pick_req),
    .grant(pick_grant), .any(accept_fire), .idx(pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      auto_bank <= '0;
      acc_valid <= 1'b0;
      acc_bank  <= '0;
    end else begin
      acc_valid <= accept_fire;
      if (accept_fire) acc_bank <= pick_idx;
      if (accept_fire && slot_tgt == AUTO_SEL) auto_bank <= pick_idx;
    end
  end

  assign stat_flags  = {paused, slot_full};
  assign next_cmd_id = id_ctr;

  assert_take_needs_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_fire |-> slot_full);
  assert_slot_drains_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_fire |=> !slot_full);
  assert_abort_drains_R2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr |=> !slot_full);
  assert_bank_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_fire |=> ((bank_busy & $past(pick_grant)) == $past(pick_grant)));
  assert_hold_paused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !accept_fire);
  assert_id_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_take |=> (id_ctr == $past(id_ctr) + 1'b1));
  assert_directed_keeps_auto_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_fire && slot_tgt != AUTO_SEL) |=> $stable(auto_bank));
endmodule

// File: tb/test_cmd_stage_dispatch.sv
module test_cmd_stage_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [5:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [NB-1:0] bank_done = '0;
  logic [NB*8-1:0] bank_intr = '0;
  logic [1:0] stat_flags;
  logic [5:0] auto_bank, acc_bank;
  logic [9:0] next_cmd_id;
  logic [NB-1:0] bank_busy;
  logic acc_valid;
  logic [NB*8-1:0] bsp_op, bsp_opt;
  logic [NB*10-1:0] bsp_id;
  logic [NB*32-1:0] bsp_row;

  int checks = 0, errors = 0;
  logic [23:0] expq [$];   // {bank[5:0], opcode[7:0], id[9:0]}
  logic [7:0] cur_op;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_stage_dispatch i_cmd_stage_dispatch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bank_done(bank_done), .bank_intr(bank_intr), .stat_flags(stat_flags),
    .auto_bank(auto_bank), .next_cmd_id(next_cmd_id), .bank_busy(bank_busy),
    .acc_valid(acc_valid), .acc_bank(acc_bank), .bsp_op(bsp_op), .bsp_opt(bsp_opt),
    .bsp_id(bsp_id), .bsp_row(bsp_row)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = 6'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic done(input logic [NB-1:0] m);
    @(negedge clk);
    bank_done = m;
    @(negedge clk);
    bank_done = '0;
  endtask

  task automatic expect_acc(input int b, input logic [7:0] op, input logic [9:0] id);
    expq.push_back({6'(b), op, id});
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every handover is compared with the next expected item
  always @(negedge clk) begin
    if (rst_n && acc_valid) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 unexpected handover bank=%0d expected=none", acc_bank);
      end else begin
        logic [23:0] e;
        e = expq.pop_front();
        check("R5 bank", 32'(acc_bank), 32'(e[23:18]));
        check("R3 opcode", 32'(bsp_op[acc_bank*8 +: 8]), 32'(e[17:10]));
        check("R8 id", 32'(bsp_id[acc_bank*10 +: 10]), 32'(e[9:0]));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    // reset state
    check("R7 reset flags", 32'(stat_flags), 0);
    check("R8 reset id", 32'(next_cmd_id), 0);
    check("R10 reset auto", 32'(auto_bank), 0);
    check("R3 reset busy", 32'(bank_busy), 0);

    // directed issue
    cur_op = 8'h14;
    wr(0, 32'h14); wr(2, 32'h21); wr(1, 2);
    wr(4, 0);
    expect_acc(2, 8'h14, 0);
    check("R1 slot full", 32'(stat_flags), 1);
    cyc(1);
    check("R3 busy set", 32'(bank_busy), 32'h04);
    check("R2 slot empty", 32'(stat_flags), 0);
    check("R3 option", 32'(bsp_opt[2*8 +: 8]), 32'h21);

    // reissue without rewrite while bank busy
    wr(4, 0);
    expect_acc(2, 8'h14, 1);
    cyc(5);
    check("R3 waits on busy", 32'(stat_flags), 1);
    check("R4 port held", 32'(bsp_id[2*10 +: 10]), 0);
    done(8'h04);
    cyc(2);
    check("R1 staged kept", 32'(bsp_id[2*10 +: 10]), 1);

    // abort
    wr(0, 32'h33);
    wr(4, 0);                // id 2 aimed at busy bank 2
    wr(5, 0);
    check("R2 abort empties", 32'(stat_flags), 0);
    done(8'h04);
    cyc(3);
    check("R2 aborted not taken", 32'(bank_busy), 0);
    wr(5, 0);
    check("R2 abort when empty", 32'(stat_flags), 0);
    check("R8 id after abort", 32'(next_cmd_id), 3);
    wr(1, 3); wr(4, 0);
    expect_acc(3, 8'h33, 3);
    cyc(2);
    done(8'h08);

    // auto select with exclusion
    wr(32, 32'hFFFF_FFFF);
    wr(1, 32'h3F); wr(4, 0);
    expect_acc(1, 8'h33, 4);
    cyc(2);
    check("R6 skip blocked bank", 32'(auto_bank), 1);
    wr(4, 0);
    expect_acc(2, 8'h33, 5);
    cyc(2);
    check("R10 auto bank", 32'(auto_bank), 2);
    wr(1, 4); wr(4, 0);
    expect_acc(4, 8'h33, 6);
    cyc(2);
    check("R10 directed keeps", 32'(auto_bank), 2);
    check("R6 blocked bank idle", 32'(bank_busy[0]), 0);

    // pause
    wr(3, 32'h04);
    bank_intr[5*8 +: 8] = 8'h08;
    cyc(1);
    check("R9 no overlap", 32'(stat_flags), 0);
    bank_intr[5*8 +: 8] = 8'h06;
    cyc(1);
    check("R7 pause flag", 32'(stat_flags), 2);
    wr(1, 5); wr(4, 0);
    cyc(4);
    check("R9 held while paused", 32'(stat_flags), 3);
    check("R9 bank idle", 32'(bank_busy[5]), 0);
    expect_acc(5, 8'h33, 7);
    bank_intr = '0;
    cyc(2);
    check("R9 resume", 32'(bank_busy[5]), 1);

    // fill remaining banks, then auto waits
    wr(1, 3); wr(4, 0); expect_acc(3, 8'h33, 8); cyc(1);
    wr(1, 6); wr(4, 0); expect_acc(6, 8'h33, 9); cyc(1);
    wr(1, 7); wr(4, 0); expect_acc(7, 8'h33, 10); cyc(1);
    wr(1, 32'h3F); wr(4, 0);
    cyc(4);
    check("R5 auto waits", 32'(stat_flags), 1);
    expect_acc(6, 8'h33, 11);
    done(8'h40);
    cyc(2);
    check("R10 auto after free", 32'(auto_bank), 6);
    wr(4, 0);
    cyc(3);
    expect_acc(3, 8'h33, 12);
    done(8'h88);              // banks 3 and 7 freed together
    cyc(2);
    check("R5 lowest wins", 32'(auto_bank), 3);
    check("R5 other stays idle", 32'(bank_busy[7]), 0);
    check("R3 scoreboard drained", expq.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule